// File: doc/BRIEF.md
# Frequency-Locked Loop Controller

This block is the digital half of a frequency-locked loop. It takes one of three candidate reference clocks and divides it by a programmable ratio. Over each period of that divided reference it counts the pulses of a divided copy of the oscillator clock. After each period it nudges a 10-bit control word up or down by one so that the count moves towards a programmed multiplier. The control word drives an external digitally controlled oscillator. Its upper five bits select one of 32 coarse taps, each roughly 8% apart in frequency. Its lower five bits are a modulation count that interpolates between neighbouring taps.

All clock-like inputs are treated as level signals sampled by the block clock `clk`. They must be synchronous to it and must run at less than half its rate. The divided oscillator clock leaves the block as a one-cycle strobe. Software can freeze the whole loop, or freeze only the modulation bits. A lock flag reports that several reference periods in a row measured exactly the multiplier. With a 32.768 kHz reference, a multiplier of 32 and an oscillator prescaler of 2, the loop settles the oscillator near 2.097 MHz.

Top module: `fll_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `tap` becomes RST_TAP (16), `mod` becomes RST_MOD (0), and `locked` and `dco_div_pulse` become 0.
- R2: `ref_sel` picks the reference. 3'b000 selects `src_xt1` and 3'b101 selects `src_xt2`. Every other code selects `src_refo`.
- R3: The reference divider gives one tick per N rising edges of the selected reference. Codes 0 to 5 of `ref_div_sel` set N to 1, 2, 4, 8, 12 and 16. Codes 6 and 7 set N to 16.
- R4: `dco_div_pulse` is high for one clock per N rising edges of `dco_clk`. Codes 0 to 5 of `dco_div_sel` set N to 1, 2, 4, 8, 16 and 32. Codes 6 and 7 set N to 32.
- R5: A measurement window is the span between two consecutive reference ticks. Its count includes a divided-oscillator pulse that falls in the same cycle as the closing tick. The first reference tick after reset only opens a window and changes nothing.
- R6: A `mult` value of 0 acts as a multiplier of 1.
- R7: The control word is {`tap`,`mod`}, with `tap` in bits 9:5. When a window closes, the word moves up by 1 if the count is below the multiplier and down by 1 if it is above. An equal count leaves the word unchanged. The new word appears one clock after the tick.
- R8: The control word saturates at 0 and at 1023 and never wraps.
- R9: While `mod_freeze` is 1, `mod` holds its value. A step then moves `tap` by 1, and `tap` saturates at 0 and 31.
- R10: While `loop_hold` is 1, `tap` and `mod` hold their values. Measurement and lock tracking continue.
- R11: `locked` goes to 1 at the close of the 4th consecutive window whose count equals the multiplier. It returns to 0 at the close of the first window that does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_xt1 | input | 1 | Candidate reference, first crystal source |
| src_refo | input | 1 | Candidate reference, internal reference oscillator |
| src_xt2 | input | 1 | Candidate reference, second crystal source |
| dco_clk | input | 1 | Oscillator clock being regulated |
| ref_sel | input | 3 | Reference source code |
| ref_div_sel | input | 3 | Reference divider code |
| dco_div_sel | input | 3 | Oscillator prescaler code |
| mult | input | MULT_W | Target pulse count per window (0 means 1) |
| loop_hold | input | 1 | Freeze the whole control word |
| mod_freeze | input | 1 | Freeze the modulation bits only |
| tap | output | 5 | Coarse tap select |
| mod | output | 5 | Modulation count |
| locked | output | 1 | Lock indicator |
| dco_div_pulse | output | 1 | One-cycle strobe per divided oscillator period |

## Verification
The assertions check the following on every cycle:
- The reset values are correct.
- The control word moves only in the cycle after a reference tick, and by at most one step.
- The word never wraps at either end.
- `loop_hold` and `mod_freeze` freeze the bits they cover.
- `locked` rises only just after a tick.

Other behaviours only the bench scenarios can show, by closing the loop through a modelled oscillator and comparing every output against a reference model each clock:
- Which source and which divide ratios are actually in use.
- That a zero multiplier behaves as one.
- That the loop settles where the multiplier says it should.
- That lock takes four matching windows.

// File: rtl/fll_pkg.sv
// Package: shared widths, step direction type and divide-ratio decoders
// for the frequency-locked loop controller.
package fll_pkg;
    localparam int TAP_W   = 5;
    localparam int MOD_W   = 5;
    localparam int WORD_W  = TAP_W + MOD_W;
    localparam int RATIO_W = 6;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Reference divide ratio: 1,2,4,8,12,16; reserved codes give 16.
    function automatic logic [RATIO_W-1:0] ref_ratio(input logic [2:0] code);
        case (code)
            3'd0:    ref_ratio = RATIO_W'(1);
            3'd1:    ref_ratio = RATIO_W'(2);
            3'd2:    ref_ratio = RATIO_W'(4);
            3'd3:    ref_ratio = RATIO_W'(8);
            3'd4:    ref_ratio = RATIO_W'(12);
            default: ref_ratio = RATIO_W'(16);
        endcase
    endfunction

    // Oscillator prescale ratio: powers of two up to 32; reserved codes give 32.
    function automatic logic [RATIO_W-1:0] dco_ratio(input logic [2:0] code);
        if (code <= 3'd5) dco_ratio = RATIO_W'(1) << code;
        else              dco_ratio = RATIO_W'(32);
    endfunction
endpackage

// File: rtl/fll_div.sv
// Module: fll_div
// Rising-edge counter that emits a one-clock tick on every Nth rising edge
// of a level input. Assumes the input is synchronous to clk and slower than
// clk/2, and that ratio is at least 1. A ratio lowered below the current
// count closes the period at the next edge.
module fll_div #(
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sig,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    logic               prev;
    logic [RATIO_W-1:0] cnt;
    logic               rise;

    // Detect a rising edge against the previous sample.
    assign rise = sig & ~prev;

    // Count edges and strobe the tick when the period completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            prev <= sig;
            tick <= 1'b0;
            if (rise) begin
                if (cnt >= ratio - RATIO_W'(1)) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt <= cnt + RATIO_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/fll_loop.sv
// Module: fll_loop
// Measurement and stepping core. Counts divided-oscillator pulses between
// reference ticks, compares with the effective multiplier, steps the
// control word by one with saturation, and tracks lock. Assumes
// mult_eff is non-zero and the two ticks come from fll_div instances.
module fll_loop
    import fll_pkg::*;
#(
    parameter int MULT_W   = 10,
    parameter int LOCK_N   = 4,
    parameter int RST_WORD = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              dco_tick,
    input  logic [MULT_W-1:0] mult_eff,
    input  logic              loop_hold,
    input  logic              mod_freeze,
    output logic [WORD_W-1:0] word,
    output logic              locked
);
    localparam int CNT_W = MULT_W + 1;
    localparam int RUN_W = $clog2(LOCK_N + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [TAP_W-1:0] TAP_MAX  = {TAP_W{1'b1}};
    localparam logic [WORD_W-1:0] WORD_MAX = {WORD_W{1'b1}};

    logic [CNT_W-1:0]  win;
    logic [CNT_W:0]    meas;
    logic              primed;
    logic [RUN_W-1:0]  run;
    step_e             dir;
    logic [WORD_W-1:0] nxt_word;
    logic [TAP_W-1:0]  cur_tap;

    assign cur_tap = word[WORD_W-1:MOD_W];
    assign meas    = {1'b0, win} + {{CNT_W{1'b0}}, dco_tick};

    // Decide the step direction from the closing window count.
    always_comb begin
        if (meas < {{(CNT_W+1-MULT_W){1'b0}}, mult_eff})      dir = STEP_UP;
        else if (meas > {{(CNT_W+1-MULT_W){1'b0}}, mult_eff}) dir = STEP_DOWN;
        else                                                  dir = STEP_NONE;
    end

    // Form the saturated next word, stepping taps only when modulation is frozen.
    always_comb begin
        nxt_word = word;
        if (dir == STEP_UP) begin
            if (mod_freeze) begin
                if (cur_tap != TAP_MAX) nxt_word = word + (WORD_W'(1) << MOD_W);
            end else if (word != WORD_MAX) begin
                nxt_word = word + WORD_W'(1);
            end
        end else if (dir == STEP_DOWN) begin
            if (mod_freeze) begin
                if (cur_tap != '0) nxt_word = word - (WORD_W'(1) << MOD_W);
            end else if (word != '0) begin
                nxt_word = word - WORD_W'(1);
            end
        end
    end

    // Accumulate pulses per window with saturation; first tick only primes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win    <= '0;
            primed <= 1'b0;
        end else if (ref_tick) begin
            win    <= '0;
            primed <= 1'b1;
        end else if (dco_tick && win != CNT_MAX) begin
            win <= win + CNT_W'(1);
        end
    end

    // Apply the step and update the lock run at each closing tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word   <= WORD_W'(RST_WORD);
            run    <= '0;
            locked <= 1'b0;
        end else if (ref_tick && primed) begin
            if (!loop_hold) word <= nxt_word;
            if (dir == STEP_NONE) begin
                if (run != RUN_W'(LOCK_N)) run <= run + RUN_W'(1);
                locked <= (run >= RUN_W'(LOCK_N - 1));
            end else begin
                run    <= '0;
                locked <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fll_ctrl.sv
// Module: fll_ctrl (top)
// Frequency-locked loop controller: selects and divides a reference,
// prescales the oscillator clock, and steers the tap/modulation word.
// Assumes every clock-like input is synchronous to clk and below clk/2.
module fll_ctrl
    import fll_pkg::*;
#(
    parameter int MULT_W  = 10,
    parameter int LOCK_N  = 4,
    parameter int RST_TAP = 16,
    parameter int RST_MOD = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_xt1,
    input  logic              src_refo,
    input  logic              src_xt2,
    input  logic              dco_clk,
    input  logic [2:0]        ref_sel,
    input  logic [2:0]        ref_div_sel,
    input  logic [2:0]        dco_div_sel,
    input  logic [MULT_W-1:0] mult,
    input  logic              loop_hold,
    input  logic              mod_freeze,
    output logic [4:0]        tap,
    output logic [4:0]        mod,
    output logic              locked,
    output logic              dco_div_pulse
);
    localparam int RST_WORD = RST_TAP * (2 ** MOD_W) + RST_MOD;

    logic              ref_src;
    logic              ref_tick;
    logic [MULT_W-1:0] mult_eff;
    logic [WORD_W-1:0] word;

    // Reference source selection; unlisted codes fall back to the internal reference.
    always_comb begin
        case (ref_sel)
            3'b000:  ref_src = src_xt1;
            3'b101:  ref_src = src_xt2;
            default: ref_src = src_refo;
        endcase
    end

    // A zero multiplier is treated as one.
    assign mult_eff = (mult == '0) ? MULT_W'(1) : mult;

    fll_div #(.RATIO_W(RATIO_W)) u_ref_div (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (ref_src),
        .ratio (ref_ratio(ref_div_sel)),
        .tick  (ref_tick)
    );

    fll_div #(.RATIO_W(RATIO_W)) u_dco_div (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (dco_clk),
        .ratio (dco_ratio(dco_div_sel)),
        .tick  (dco_div_pulse)
    );

    fll_loop #(.MULT_W(MULT_W), .LOCK_N(LOCK_N), .RST_WORD(RST_WORD)) u_loop (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .dco_tick   (dco_div_pulse),
        .mult_eff   (mult_eff),
        .loop_hold  (loop_hold),
        .mod_freeze (mod_freeze),
        .word       (word),
        .locked     (locked)
    );

    assign tap = word[WORD_W-1:MOD_W];
    assign mod = word[MOD_W-1:0];
endmodule

// File: rtl/fll_ctrl_chk.sv
// Module: fll_ctrl_chk
// Property checker bound into fll_ctrl. Watches the output word, the lock
// flag and the internal reference tick. Assumes a synchronous active-low reset.
module fll_ctrl_chk #(
    parameter int RST_TAP = 16,
    parameter int RST_MOD = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] tap,
    input logic [4:0] mod,
    input logic       locked,
    input logic       ref_tick,
    input logic       loop_hold,
    input logic       mod_freeze
);
    logic [9:0] w;
    assign w = {tap, mod};

    // R1: the cycle after a reset edge shows the reset state
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (tap == 5'(RST_TAP) && mod == 5'(RST_MOD) && !locked));

    // R7: the word changes only in the cycle after a reference tick
    p_change_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && w != $past(w)) |-> $past(ref_tick));

    // R7: without mod freeze, a change is a single unit step
    p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mod_freeze)) |->
            (w == $past(w) || w == $past(w) + 10'd1 || w == $past(w) - 10'd1));

    // R8: no wrap at the top of the range
    p_no_wrap_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(w) == 10'd1023) |-> w != 10'd0);

    // R8: no wrap at the bottom of the range
    p_no_wrap_bot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(w) == 10'd0) |-> w != 10'd1023);

    // R9: frozen modulation bits do not move
    p_mod_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mod_freeze)) |-> mod == $past(mod));

    // R10: a held loop keeps the whole word
    p_word_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(loop_hold)) |-> w == $past(w));

    // R11: lock only rises just after a reference tick
    p_lock_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(locked)) |-> $past(ref_tick));
endmodule

bind fll_ctrl fll_ctrl_chk #(.RST_TAP(RST_TAP), .RST_MOD(RST_MOD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tap        (tap),
    .mod        (mod),
    .locked     (locked),
    .ref_tick   (ref_tick),
    .loop_hold  (loop_hold),
    .mod_freeze (mod_freeze)
);

// File: tb/sim_fll_ctrl.sv
`timescale 1ns/1ps
// Bench for fll_ctrl. It closes the loop through an oscillator model whose
// half period shrinks as the control word rises, and it compares every
// output against a behavioural model on each clock.
module sim_fll_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_xt1 = 1'b0, src_refo = 1'b0, src_xt2 = 1'b0, dco_clk = 1'b0;
    logic [2:0] ref_sel = 3'b010, ref_div_sel = 3'd0, dco_div_sel = 3'd0;
    logic [9:0] mult = 10'd16;
    logic       loop_hold = 1'b0, mod_freeze = 1'b0;
    logic [4:0] tap, mod;
    logic       locked, dco_div_pulse;

    int n_cmp = 0, n_bad = 0;
    string phase = "R1";

    // model state
    int m_rprev, m_rcnt, m_rtick, m_dprev, m_dcnt, m_dtick;
    int m_win, m_primed, m_word, m_run, m_lock;
    // plant state
    int cyc_no = 0, dco_half = 0;

    always #2.5 clk = ~clk;

    fll_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_xt1(src_xt1), .src_refo(src_refo),
        .src_xt2(src_xt2), .dco_clk(dco_clk), .ref_sel(ref_sel),
        .ref_div_sel(ref_div_sel), .dco_div_sel(dco_div_sel), .mult(mult),
        .loop_hold(loop_hold), .mod_freeze(mod_freeze), .tap(tap), .mod(mod),
        .locked(locked), .dco_div_pulse(dco_div_pulse)
    );

    function automatic int rratio(int c);
        int t[8] = '{1, 2, 4, 8, 12, 16, 16, 16};
        return t[c];
    endfunction

    function automatic int dratio(int c);
        return (c <= 5) ? (1 << c) : 32;
    endfunction

    // Advance the model by one clock edge using the inputs now applied.
    task automatic model_step();
        int src, rt, rc, dt, dc, meas, m, w;
        if (!rst_n) begin
            m_rprev = 0; m_rcnt = 0; m_rtick = 0; m_dprev = 0; m_dcnt = 0; m_dtick = 0;
            m_win = 0; m_primed = 0; m_word = 512; m_run = 0; m_lock = 0;
            return;
        end
        src = (ref_sel == 3'b000) ? int'(src_xt1) : (ref_sel == 3'b101) ? int'(src_xt2) : int'(src_refo);
        rt = 0; rc = m_rcnt;
        if (src == 1 && m_rprev == 0) begin
            if (m_rcnt >= rratio(ref_div_sel) - 1) begin rc = 0; rt = 1; end else rc = m_rcnt + 1;
        end
        dt = 0; dc = m_dcnt;
        if (dco_clk == 1'b1 && m_dprev == 0) begin
            if (m_dcnt >= dratio(dco_div_sel) - 1) begin dc = 0; dt = 1; end else dc = m_dcnt + 1;
        end
        if (m_rtick == 1) begin
            meas = m_win + m_dtick;
            m = (mult == 0) ? 1 : int'(mult);
            if (m_primed == 1) begin
                w = m_word;
                if (meas != m && !loop_hold) begin
                    if (mod_freeze) begin
                        if (meas < m && (w >> 5) < 31) w = w + 32;
                        if (meas > m && (w >> 5) > 0)  w = w - 32;
                    end else begin
                        if (meas < m && w < 1023) w = w + 1;
                        if (meas > m && w > 0)    w = w - 1;
                    end
                end
                m_word = w;
                if (meas == m) begin
                    m_lock = (m_run >= 3) ? 1 : 0;
                    if (m_run < 4) m_run = m_run + 1;
                end else begin
                    m_run = 0; m_lock = 0;
                end
            end
            m_win = 0; m_primed = 1;
        end else if (m_dtick == 1 && m_win < 2047) begin
            m_win = m_win + 1;
        end
        m_rprev = src; m_rcnt = rc; m_rtick = rt;
        m_dprev = int'(dco_clk); m_dcnt = dc; m_dtick = dt;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: model step, then at the falling edge compare and drive the plant.
    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            int h;
            model_step();
            @(negedge clk);
            chk({tap, mod} === 10'(m_word), {phase, " word"}, int'({tap, mod}), m_word);
            chk(locked === 1'(m_lock), {phase, " lock"}, int'(locked), m_lock);
            chk(dco_div_pulse === 1'(m_dtick), {phase, " pulse"}, int'(dco_div_pulse), m_dtick);
            cyc_no++;
            src_refo = (cyc_no % 64) < 32;
            src_xt1  = (cyc_no % 80) < 40;
            src_xt2  = (cyc_no % 16) < 8;
            h = 1 + (1023 - int'({tap, mod})) / 128;
            dco_half++;
            if (dco_half >= h) begin dco_clk = ~dco_clk; dco_half = 0; end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(190000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int w0, gap;
        // R1 reset state
        cyc(4);
        chk(tap == 5'd16 && mod == 5'd0, "R1 reset word", int'({tap, mod}), 512);
        chk(!locked && !dco_div_pulse, "R1 reset flags", int'(locked), 0);
        rst_n = 1'b1;

        // R7/R5 closed loop from reset to lock at multiplier 16
        phase = "R7";
        cyc(20000);
        chk(locked == 1'b1, "R7 lock at mult 16", int'(locked), 1);
        chk(tap == 5'd24, "R7 settled tap", int'(tap), 24);

        // R6 zero multiplier behaves as one, prescaler 32
        phase = "R6"; mult = 10'd0; dco_div_sel = 3'd5;
        cyc(25000);
        chk(locked == 1'b1, "R6 lock with mult 0", int'(locked), 1);
        chk(tap >= 5'd28, "R6 settled tap", int'(tap), 28);

        // R8 upper saturation
        phase = "R8"; mult = 10'd1023; dco_div_sel = 3'd0;
        cyc(10000);
        chk({tap, mod} == 10'd1023, "R8 top saturation", int'({tap, mod}), 1023);
        chk(locked == 1'b0, "R11 no lock while mismatched", int'(locked), 0);

        // R9 modulation frozen, tap walks down to 0
        phase = "R9"; mult = 10'd1; mod_freeze = 1'b1;
        cyc(3000);
        chk(tap == 5'd0 && mod == 5'd31, "R9 tap only steps", int'({tap, mod}), 31);

        // R8 lower saturation
        phase = "R8"; mod_freeze = 1'b0;
        cyc(3000);
        chk({tap, mod} == 10'd0, "R8 bottom saturation", int'({tap, mod}), 0);

        // R3 divide-by-12 reference, R11 lock
        phase = "R3"; ref_div_sel = 3'd4; dco_div_sel = 3'd3; mult = 10'd6;
        cyc(6000);
        chk(locked == 1'b1, "R3 ratio 12 gives 6 counts", int'(locked), 1);
        chk(tap == 5'd0, "R3 tap unchanged", int'(tap), 0);

        // R10 hold keeps the word while lock tracking continues
        phase = "R10"; loop_hold = 1'b1; mult = 10'd1023; w0 = int'({tap, mod});
        cyc(2000);
        chk(int'({tap, mod}) == w0, "R10 word held", int'({tap, mod}), w0);
        chk(locked == 1'b0, "R11 lock cleared on mismatch", int'(locked), 0);

        // R4 reserved prescale code gives 32 oscillator periods between pulses
        phase = "R4"; dco_div_sel = 3'd7;
        cyc(1200);
        gap = 0;
        while (dco_div_pulse !== 1'b1 && gap < 2000) begin cyc(1); gap++; end
        gap = 0;
        cyc(1);
        while (dco_div_pulse !== 1'b1 && gap < 2000) begin cyc(1); gap++; end
        chk(gap + 1 == 512, "R4 pulse spacing code 7", gap + 1, 512);

        // R2 source selection: first crystal, period 80 -> 5 counts
        phase = "R2"; loop_hold = 1'b0; ref_sel = 3'b000; ref_div_sel = 3'd0;
        dco_div_sel = 3'd0; mult = 10'd5;
        cyc(1500);
        chk(locked == 1'b1, "R2 code 000 selects xt1", int'(locked), 1);
        // second crystal, period 16 -> 1 count
        ref_sel = 3'b101; mult = 10'd1;
        cyc(1000);
        chk(locked == 1'b1, "R2 code 101 selects xt2", int'(locked), 1);
        // fallback code selects internal reference, period 64 -> 4 counts
        ref_sel = 3'b011; mult = 10'd4;
        cyc(1500);
        chk(locked == 1'b1, "R2 code 011 falls back", int'(locked), 1);

        // R3/R4 reserved codes: /16 reference, /32 prescale -> 2 counts
        phase = "R3"; ref_div_sel = 3'd7; dco_div_sel = 3'd6; mult = 10'd2;
        cyc(8000);
        chk(locked == 1'b1, "R3 reserved reference code acts as 16", int'(locked), 1);
        chk(tap == 5'd0, "R4 reserved prescale keeps tap", int'(tap), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule